// File: doc/BRIEF.md
# Associative Tag Store with RAM-Based Match Tables

This block holds the tags of a set-associative instruction cache and answers the question "is this line present, and in which way?" The set is selected from the most significant address bits. Within the selected set, the tag is not compared against every way in parallel. The tag is cut into small chunks. Each chunk value addresses a small RAM whose word is a per-way bit vector. ANDing the chunk vectors, and masking the result with the set's valid bits, gives the match vector of the set. A lookup is accepted in one cycle and its result is registered on the next edge, so a hit costs nothing beyond that single result cycle.

On a miss, the surrounding cache issues an install request. The block picks a victim way from a per-set round-robin counter. It then spends three cycles on the install. First it clears the victim's old tag from the match tables. Next it writes the new tag's bits, the stored tag and the valid flag. Last it pulses a done strobe, which the data side uses to write the line. Lookups are stalled while an install runs.

Top module: `cam_tag_store`

## Requirements
- R1: After reset, lkp_ready is 1, upd_busy, upd_done and res_valid are 0, and every lookup misses.
- R2: An address is split as {set[15:12], tag[11:4], offset[3:0]} by default. The set comes from the top bits. The offset bits have no effect on a lookup, and the same tag in another set does not hit.
- R3: A lookup presented with lkp_valid while lkp_ready is 1 produces res_valid for exactly one cycle on the next clock edge, together with res_hit and res_way.
- R4: res_hit is 1 only when a valid way of the selected set holds the looked-up tag. res_way is then that way's binary index.
- R5: An install request is taken when upd_req is 1 and upd_busy is 0. upd_busy is then 1 for exactly three cycles. upd_done is 1 only in the third cycle, with upd_set and upd_way naming the written line. upd_busy is 0 on the cycle after.
- R6: While upd_busy is 1, lkp_ready is 0 and a presented lookup is dropped: no res_valid follows it.
- R7: After an install completes, a lookup of the installed tag in that set hits, with res_way equal to the upd_way reported for that install.
- R8: Victims are chosen per set in round-robin order. The first install into a set uses way 0, each later one uses the next way, way 31 is followed by way 0, and each set counts independently.
- R9: When a way is reused, its previous tag misses afterwards. Tags that share some chunk values with installed tags, but are not themselves installed, miss. Other ways' tags keep hitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_ready | output | 1 | Lookup can be accepted this cycle |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_way | output | log2(WAYS) | Hitting way index |
| upd_req | input | 1 | Install request for a missed line |
| upd_addr | input | ADDR_W | Address whose tag is installed |
| upd_busy | output | 1 | Install in progress |
| upd_done | output | 1 | Final install cycle; data line write strobe |
| upd_set | output | SET_W | Set of the line being written |
| upd_way | output | log2(WAYS) | Victim way of the line being written |

## Verification
A lookup driven before one rising edge has its result on the following edge. The scoreboard therefore pushes the expected hit and way when the request is driven and pops them at the next falling edge that shows res_valid. Any result with no pending entry is an error. An install is followed falling edge by falling edge: busy without done on the first two, done with the set and way on the third, idle on the fourth. A lookup is injected into that window to confirm that it is dropped. Expected ways come from a bench model of the per-set round-robin counters and the stored tags.

// File: rtl/cam_tag_pkg.sv
// Shared types for the associative tag store.
package cam_tag_pkg;

    // Phases of a tag install: idle, remove old tag, write new tag, data strobe.
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_SET   = 2'd2,
        UPD_DATA  = 2'd3
    } upd_state_t;

endpackage

// File: rtl/ctag_chunk_ram.sv
// One match table: for every (set, chunk value) pair, a vector with one bit
// per way saying whether that way's tag has this chunk value.
// Assumes: a single bit is written per cycle; reads are combinational.
module ctag_chunk_ram #(
    parameter int SET_W   = 4,
    parameter int CHUNK_W = 4,
    parameter int WAYS    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SET_W+CHUNK_W-1:0]         rd_addr,
    output logic [WAYS-1:0]                  rd_vec,
    input  logic                             wr_en,
    input  logic [SET_W+CHUNK_W-1:0]         wr_addr,
    input  logic [$clog2(WAYS)-1:0]          wr_way,
    input  logic                             wr_bit
);
    localparam int DEPTH = 1 << (SET_W + CHUNK_W);

    logic [WAYS-1:0] mem_q [DEPTH];

    // Clear all vectors on reset; otherwise update one way bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr][wr_way] <= wr_bit;
        end
    end

    // Read the vector of the addressed set and chunk value.
    assign rd_vec = mem_q[rd_addr];

    // A bit may only be set directly after the removal step of the same install.
    AST_SET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit) |-> $past(wr_en && !wr_bit)); // R5

endmodule

// File: rtl/ctag_way_store.sv
// Per-way bookkeeping: valid flags, the tag held by each way (needed to
// remove it from the match tables on eviction) and per-set round-robin
// victim counters.
// Assumes: WAYS is a power of two so the counters wrap naturally.
module ctag_way_store #(
    parameter int SET_W = 4,
    parameter int WAYS  = 32,
    parameter int TAG_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SET_W-1:0]          rd_set,
    output logic [WAYS-1:0]           valid_vec,
    input  logic [SET_W-1:0]          q_set,
    output logic [$clog2(WAYS)-1:0]   victim_way,
    output logic [TAG_W-1:0]          victim_tag,
    input  logic                      inval_en,
    input  logic                      inst_en,
    input  logic [SET_W-1:0]          wr_set,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [TAG_W-1:0]          wr_tag
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int LINES = SETS * WAYS;

    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAY_W-1:0] rr_q    [SETS];
    logic [TAG_W-1:0] tag_q   [LINES];

    // Valid flags and victim counters: cleared on reset, updated by installs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            if (inval_en) valid_q[wr_set][wr_way] <= 1'b0;
            if (inst_en) begin
                valid_q[wr_set][wr_way] <= 1'b1;
                rr_q[wr_set]            <= rr_q[wr_set] + 1'b1;
            end
        end
    end

    // Stored tag per line, written on the second install step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else if (inst_en) begin
            tag_q[{wr_set, wr_way}] <= wr_tag;
        end
    end

    // Combinational views for lookup and victim selection.
    assign valid_vec  = valid_q[rd_set];
    assign victim_way = rr_q[q_set];
    assign victim_tag = tag_q[{q_set, rr_q[q_set]}];

    // The victim must already be invalid when the new tag is written.
    AST_VICTIM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |-> !valid_q[wr_set][wr_way]); // R9

endmodule

// File: rtl/ctag_update_fsm.sv
// Sequencer for a tag install: latches the request and victim, then steps
// through removal of the old tag, writing of the new tag and the data strobe.
// Assumes: a request is only taken while idle.
module ctag_update_fsm
    import cam_tag_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int TAG_W = 8,
    parameter int WAY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [SET_W-1:0]   req_set,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [WAY_W-1:0]   victim_way,
    input  logic [TAG_W-1:0]   victim_tag,
    output logic               busy,
    output logic               done,
    output logic               clr_en,
    output logic               set_en,
    output logic [SET_W-1:0]   cur_set,
    output logic [WAY_W-1:0]   cur_way,
    output logic [TAG_W-1:0]   cur_new_tag,
    output logic [TAG_W-1:0]   cur_old_tag
);
    upd_state_t state_q, state_d;
    logic       accept;

    assign accept = req && (state_q == UPD_IDLE);

    // Next-state selection for the three install steps.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  if (accept) state_d = UPD_CLEAR;
            UPD_CLEAR: state_d = UPD_SET;
            UPD_SET:   state_d = UPD_DATA;
            UPD_DATA:  state_d = UPD_IDLE;
            default:   state_d = UPD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request and the chosen victim at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_set     <= '0;
            cur_way     <= '0;
            cur_new_tag <= '0;
            cur_old_tag <= '0;
        end else if (accept) begin
            cur_set     <= req_set;
            cur_way     <= victim_way;
            cur_new_tag <= req_tag;
            cur_old_tag <= victim_tag;
        end
    end

    assign busy   = (state_q != UPD_IDLE);
    assign clr_en = (state_q == UPD_CLEAR);
    assign set_en = (state_q == UPD_SET);
    assign done   = (state_q == UPD_DATA);

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (busy && !done)); // R5
    AST_DONE_THIRD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req && !busy, 3)); // R5
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5

endmodule

// File: rtl/cam_tag_store.sv
// Tag store for a set-associative instruction cache. The set comes from the
// top address bits; the tag is matched through chunk-indexed RAM tables
// that return per-way bit vectors. Lookup results appear one edge after
// acceptance. Installs take three cycles and stall lookups.
// Assumes: the cache installs only tags that missed, so at most one way of
// a set matches; TAG_W is a multiple of CHUNK_W; WAYS is a power of two.
module cam_tag_store
    import cam_tag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 4,
    parameter int SET_W   = 4,
    parameter int WAYS    = 32,
    parameter int CHUNK_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lkp_valid,
    input  logic [ADDR_W-1:0]         lkp_addr,
    output logic                      lkp_ready,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic [$clog2(WAYS)-1:0]   res_way,
    input  logic                      upd_req,
    input  logic [ADDR_W-1:0]         upd_addr,
    output logic                      upd_busy,
    output logic                      upd_done,
    output logic [SET_W-1:0]          upd_set,
    output logic [$clog2(WAYS)-1:0]   upd_way
);
    localparam int TAG_W   = ADDR_W - SET_W - OFF_W;
    localparam int N_CHUNK = TAG_W / CHUNK_W;
    localparam int WAY_W   = $clog2(WAYS);

    logic [SET_W-1:0] lkp_set, req_set, cur_set;
    logic [TAG_W-1:0] lkp_tag, req_tag, cur_new_tag, cur_old_tag, victim_tag;
    logic [WAY_W-1:0] victim_way, cur_way, hit_way;
    logic [WAYS-1:0]  valid_vec, match_vec, hit_vec;
    logic [WAYS-1:0]  chunk_vec [N_CHUNK];
    logic             clr_en, set_en, accept;
    logic             unused_offset_bits;

    // Address split: set from the top, tag in the middle, offset ignored.
    assign lkp_set = lkp_addr[ADDR_W-1 -: SET_W];
    assign lkp_tag = lkp_addr[ADDR_W-SET_W-1 : OFF_W];
    assign req_set = upd_addr[ADDR_W-1 -: SET_W];
    assign req_tag = upd_addr[ADDR_W-SET_W-1 : OFF_W];
    assign unused_offset_bits = ^{lkp_addr[OFF_W-1:0], upd_addr[OFF_W-1:0]};

    // Install sequencer.
    ctag_update_fsm #(.SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (upd_req),
        .req_set     (req_set),
        .req_tag     (req_tag),
        .victim_way  (victim_way),
        .victim_tag  (victim_tag),
        .busy        (upd_busy),
        .done        (upd_done),
        .clr_en      (clr_en),
        .set_en      (set_en),
        .cur_set     (cur_set),
        .cur_way     (cur_way),
        .cur_new_tag (cur_new_tag),
        .cur_old_tag (cur_old_tag)
    );

    // Valid flags, stored tags and victim counters.
    ctag_way_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_ways (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (lkp_set),
        .valid_vec  (valid_vec),
        .q_set      (req_set),
        .victim_way (victim_way),
        .victim_tag (victim_tag),
        .inval_en   (clr_en),
        .inst_en    (set_en),
        .wr_set     (cur_set),
        .wr_way     (cur_way),
        .wr_tag     (cur_new_tag)
    );

    // One match table per tag chunk; removal uses the old tag, setting the new one.
    for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
        logic [SET_W+CHUNK_W-1:0] wr_addr;
        logic [SET_W+CHUNK_W-1:0] rd_addr;

        assign rd_addr = {lkp_set, lkp_tag[c*CHUNK_W +: CHUNK_W]};
        assign wr_addr = set_en ? {cur_set, cur_new_tag[c*CHUNK_W +: CHUNK_W]}
                                : {cur_set, cur_old_tag[c*CHUNK_W +: CHUNK_W]};

        ctag_chunk_ram #(.SET_W(SET_W), .CHUNK_W(CHUNK_W), .WAYS(WAYS)) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_addr (rd_addr),
            .rd_vec  (chunk_vec[c]),
            .wr_en   (clr_en | set_en),
            .wr_addr (wr_addr),
            .wr_way  (cur_way),
            .wr_bit  (set_en)
        );
    end

    // A way matches only if every chunk table agrees.
    always_comb begin
        match_vec = '1;
        for (int c = 0; c < N_CHUNK; c++) match_vec &= chunk_vec[c];
    end

    assign hit_vec = match_vec & valid_vec;

    // Binary index of the single matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way |= WAY_W'(w);
        end
    end

    assign lkp_ready = !upd_busy;
    assign accept    = lkp_valid && lkp_ready;
    assign upd_set   = cur_set;
    assign upd_way   = cur_way;

    // Result register: one edge after an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_way   <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_hit <= |hit_vec;
                res_way <= hit_way;
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $onehot0(hit_vec)); // R4
    AST_NO_RESULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && lkp_valid) |=> !res_valid); // R6

endmodule

// File: tb/cam_tag_store_tb.sv
`timescale 1ns/1ps
module cam_tag_store_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lkp_valid = 1'b0;
    logic [15:0] lkp_addr = '0;
    logic       lkp_ready;
    logic       res_valid, res_hit;
    logic [4:0] res_way;
    logic       upd_req = 1'b0;
    logic [15:0] upd_addr = '0;
    logic       upd_busy, upd_done;
    logic [3:0] upd_set;
    logic [4:0] upd_way;

    int checks = 0;
    int fails  = 0;

    // Scoreboard queues.
    int    q_hit[$];
    int    q_way[$];
    string q_req[$];

    // Reference model.
    logic [7:0] tag_m   [16][32];
    bit         valid_m [16][32];
    int         rr_m    [16];

    always #4 clk = ~clk;

    cam_tag_store u_dut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_ready(lkp_ready),
        .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .upd_req(upd_req), .upd_addr(upd_addr), .upd_busy(upd_busy),
        .upd_done(upd_done), .upd_set(upd_set), .upd_way(upd_way)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop one expectation per result, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_hit.size() == 0) begin
                check(1'b0, "R6", "unexpected result", 1, 0);
            end else begin
                int eh, ew;
                string r;
                eh = q_hit.pop_front();
                ew = q_way.pop_front();
                r  = q_req.pop_front();
                check(res_hit == eh[0], r, "res_hit", res_hit, eh);
                if (eh != 0) check(res_way == ew[4:0], r, "res_way", res_way, ew);
            end
        end
    end

    // Driver: lookup with the expected result from the model.
    task automatic lookup(input logic [3:0] s, input logic [7:0] t,
                          input logic [3:0] off, input string req);
        int eh = 0;
        int ew = 0;
        for (int w = 0; w < 32; w++) begin
            if (valid_m[s][w] && tag_m[s][w] == t) begin eh = 1; ew = w; end
        end
        q_hit.push_back(eh); q_way.push_back(ew); q_req.push_back(req);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_addr  = {s, t, off};
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic model_install(input logic [3:0] s, input logic [7:0] t);
        tag_m[s][rr_m[s]]   = t;
        valid_m[s][rr_m[s]] = 1'b1;
        rr_m[s] = (rr_m[s] + 1) % 32;
    endtask

    // Driver: install with cycle-by-cycle handshake checks.
    task automatic install(input logic [3:0] s, input logic [7:0] t);
        int ew;
        @(negedge clk);
        while (upd_busy) @(negedge clk);
        ew = rr_m[s];
        upd_req  = 1'b1;
        upd_addr = {s, t, 4'h0};
        @(negedge clk);
        upd_req = 1'b0;
        check(upd_busy && !upd_done, "R5", "step1 busy/done", {upd_busy, upd_done}, 2);
        @(negedge clk);
        check(upd_busy && !upd_done, "R5", "step2 busy/done", {upd_busy, upd_done}, 2);
        @(negedge clk);
        check(upd_busy && upd_done, "R5", "step3 busy/done", {upd_busy, upd_done}, 3);
        check(upd_set == s, "R5", "upd_set", upd_set, s);
        check(upd_way == ew[4:0], "R8", "upd_way", upd_way, ew);
        @(negedge clk);
        check(!upd_busy && lkp_ready, "R5", "idle after done", upd_busy, 0);
        model_install(s, t);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            rr_m[s] = 0;
            for (int w = 0; w < 32; w++) begin tag_m[s][w] = '0; valid_m[s][w] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(lkp_ready == 1'b1, "R1", "lkp_ready", lkp_ready, 1);
        check(upd_busy == 1'b0 && upd_done == 1'b0, "R1", "busy/done", {upd_busy, upd_done}, 0);
        check(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
        lookup(4'h3, 8'h5A, 4'h0, "R1");
        lookup(4'h0, 8'h00, 4'h0, "R1");

        // R7 R3 first install and hit
        install(4'h3, 8'h5A);
        lookup(4'h3, 8'h5A, 4'h0, "R7");
        lookup(4'h3, 8'h5A, 4'hF, "R2");   // offset ignored
        lookup(4'h4, 8'h5A, 4'h0, "R2");   // other set misses
        lookup(4'h3, 8'hA5, 4'h0, "R4");

        // R9 partially overlapping tags
        install(4'h3, 8'h5B);
        lookup(4'h3, 8'h5B, 4'h0, "R7");
        lookup(4'h3, 8'h4A, 4'h0, "R9");
        lookup(4'h3, 8'h4B, 4'h0, "R9");
        lookup(4'h3, 8'h5A, 4'h0, "R9");

        // R6 lookup during an install is dropped
        @(negedge clk);
        upd_req  = 1'b1;
        upd_addr = {4'h3, 8'h11, 4'h0};
        @(negedge clk);
        upd_req   = 1'b0;
        lkp_valid = 1'b1;
        lkp_addr  = {4'h3, 8'h5A, 4'h0};
        check(lkp_ready == 1'b0, "R6", "lkp_ready while busy", lkp_ready, 0);
        @(negedge clk);
        lkp_valid = 1'b0;
        check(res_valid == 1'b0, "R6", "res_valid after stalled lookup", res_valid, 0);
        @(negedge clk);
        check(upd_done && upd_way == 5'd2, "R8", "stall install way", upd_way, 2);
        @(negedge clk);
        model_install(4'h3, 8'h11);
        lookup(4'h3, 8'h11, 4'h0, "R7");

        // R8 independent counter in another set
        install(4'h7, 8'h5A);
        lookup(4'h7, 8'h5A, 4'h0, "R8");
        lookup(4'h3, 8'h5A, 4'h0, "R8");

        // R8 fill set 3 and wrap
        for (int i = 0; i < 29; i++) install(4'h3, 8'(8'h80 + i));
        lookup(4'h3, 8'h80, 4'h0, "R7");
        lookup(4'h3, 8'h9C, 4'h0, "R7");
        install(4'h3, 8'hF0);              // wraps to way 0, evicts 0x5A
        lookup(4'h3, 8'hF0, 4'h0, "R7");
        lookup(4'h3, 8'h5A, 4'h0, "R9");
        lookup(4'h3, 8'h5B, 4'h0, "R9");
        lookup(4'h3, 8'hFA, 4'h0, "R9");
        lookup(4'h7, 8'h5A, 4'h0, "R9");

        repeat (3) @(negedge clk);
        check(q_hit.size() == 0, "R3", "pending results", q_hit.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule